// File: doc/BRIEF.md
# Decode Stage Skid-Buffer Controller

This block sits in an in-order pipeline between a fetch side that delivers a packed group of up to `GRP_W` instruction entries per cycle and a rename side that accepts up to `DEC_W` entries per cycle. Each entry carries a data word and a kill flag. Killed entries are dropped and do not use an output slot. Live entries move downstream in order. The result appears on the output registers one cycle after the group is presented.

Backpressure is handled by a five-state controller with the states Idle, Running, Blocked, Unblocking and Squashing. The downstream side raises its stall with a set pulse and drops it with a clear pulse. The stage then holds the stall as a level. While stalled, or when a group cannot be fully drained, the pending entries are parked in a skid buffer and a one-cycle block pulse goes upstream. The skid buffer holds `(UP_DLY + 1) * GRP_W` entries. After the stall clears, the stage empties the skid buffer before it sends a one-cycle unblock pulse. A flush input from a later stage discards everything that is buffered.

If a block request and an unblock request arise in the same cycle, they cancel each other and neither pulse is sent.

Top module: `decode_skid_ctrl`

## Requirements
- R1: After reset the stage is Idle. `out_cnt` is 0, no pulse is driven and the skid buffer is empty.
- R2: When the stage is not stalled, the live entries of an input group leave on `out_data` one cycle later. They keep their order, and slot 0 (bits `[DW-1:0]`) holds the first one. At most `DEC_W` entries leave per cycle, and `out_cnt` gives how many left.
- R3: An entry whose `in_kill` bit is set, whether it comes from the input group or from the skid buffer, is consumed without using an output slot.
- R4: Scanning stops once `DEC_W` live entries have been sent. Any entries of the group beyond that point, killed or not, go into the skid buffer in order. The stage becomes Blocked and `up_block` pulses for one cycle.
- R5: The stall is a level. A set pulse raises it and a clear pulse lowers it, and the clear wins if both arrive together. While the stall is up, nothing is sent and the whole input group is appended to the skid buffer. `up_block` pulses only in the cycle the stage enters Blocked.
- R6: When the stall clears in Blocked with a non-empty skid buffer, the stage enters Unblocking. In Unblocking it sends up to `DEC_W` live entries per cycle from the skid buffer head and appends any new group to the tail. When the buffer ends a cycle empty, `up_unblock` pulses and the stage enters Running.
- R7: When the stall clears in Blocked with an empty skid buffer, `up_unblock` pulses at once. The group in that cycle is forwarded as in Running.
- R8: If one cycle requests both a block and an unblock, neither pulse is driven. This happens when the stall clears with an empty skid buffer and the group has leftovers. The stage ends that cycle Blocked.
- R9: Flush is checked before the stall. It empties the skid buffer and drops the current group, sends nothing and enters Squashing. It pulses `up_unblock` only if the stage was Blocked or Unblocking, and it never pulses `up_block`.
- R10: Squashing lasts until a cycle with no flush and no stall. That cycle enters Running and forwards its group normally. A stall in Squashing leads to Blocked with a block pulse.
- R11: The skid buffer holds `(UP_DLY + 1) * GRP_W` entries and is never overfilled. A clear pulse while no stall is held is a protocol error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_cnt | input | $clog2(GRP_W+1) | Number of entries in the input group |
| in_data | input | GRP_W*DW | Packed input entries, entry k at bits [k*DW +: DW] |
| in_kill | input | GRP_W | Kill flag for each input entry |
| ds_stall_set | input | 1 | Downstream pulse that raises the stall |
| ds_stall_clr | input | 1 | Downstream pulse that lowers the stall |
| flush | input | 1 | Squash request from a later stage |
| out_cnt | output | $clog2(DEC_W+1) | Number of entries sent this cycle |
| out_data | output | DEC_W*DW | Sent entries, slot j at bits [j*DW +: DW] |
| up_block | output | 1 | One-cycle request telling upstream to stop |
| up_unblock | output | 1 | One-cycle request telling upstream to resume |

## Verification
Two functions can fall in the same cycle. The stage can leave Blocked, which asks for an unblock, while the group it then forwards leaves entries behind, which asks for a block. The bench provokes this with a stall that starts with no input. It then clears the stall in the same cycle as a full group larger than `DEC_W`. The cycle is judged correct if the first `DEC_W` entries appear on the output with neither pulse, and the next cycle drains the rest with a lone unblock pulse. Flush arriving while the stall is still held is the second overlap. It must win, produce an unblock pulse and no block pulse, and the entries parked earlier must never reappear.

// File: rtl/dsb_pkg.sv
`timescale 1ns/1ps
package dsb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_BLK  = 3'd2,
    ST_UNB  = 3'd3,
    ST_SQ   = 3'd4
  } dsb_state_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_GRP  = 2'd1,
    SRC_SKID = 2'd2
  } dsb_src_e;

  // Skid capacity: one group per cycle of upstream latency, plus the one in flight.
  function automatic int skid_depth(input int up_dly, input int grp_w);
    return (up_dly + 1) * grp_w;
  endfunction

  // Stall level after this cycle's pulses; the clear pulse dominates.
  function automatic logic stall_level(input logic held, input logic set_p, input logic clr_p);
    return (held | set_p) & ~clr_p;
  endfunction

  // Opposing upstream requests in one cycle cancel: {block, unblock}.
  function automatic logic [1:0] settle_pulses(input logic blk_req, input logic unb_req);
    return {blk_req & ~unb_req, unb_req & ~blk_req};
  endfunction

endpackage

// File: rtl/dsb_pick.sv
`timescale 1ns/1ps
module dsb_pick #(
  parameter int N   = 4,
  parameter int W   = 2,
  parameter int DW  = 16,
  localparam int NCW = $clog2(N + 1),
  localparam int OCW = $clog2(W + 1)
) (
  input  logic [NCW-1:0]  cnt,
  input  logic [N*DW-1:0] data,
  input  logic [N-1:0]    kill,
  output logic [OCW-1:0]  out_n,
  output logic [W*DW-1:0] out_data,
  output logic [NCW-1:0]  used_n
);

  always_comb begin
    int emitted;
    int used;
    emitted  = 0;
    used     = 0;
    out_data = '0;
    for (int i = 0; i < N; i++) begin
      if (i < int'(cnt) && emitted < W) begin
        used = i + 1;
        if (!kill[i]) begin
          out_data[emitted*DW +: DW] = data[i*DW +: DW];
          emitted = emitted + 1;
        end
      end
    end
    out_n  = OCW'(emitted);
    used_n = NCW'(used);
  end

endmodule

// File: rtl/dsb_skid.sv
`timescale 1ns/1ps
module dsb_skid #(
  parameter int DEPTH = 8,
  parameter int GW    = 4,
  parameter int DW    = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int GCW  = $clog2(GW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [CW-1:0]     pop_n,
  input  logic [GCW-1:0]    push_n,
  input  logic [GW*DW-1:0]  push_data,
  input  logic [GW-1:0]     push_kill,
  output logic [DEPTH*DW-1:0] ent_data,
  output logic [DEPTH-1:0]  ent_kill,
  output logic [CW-1:0]     cnt
);

  logic [DEPTH*DW-1:0] nxt_data;
  logic [DEPTH-1:0]    nxt_kill;
  logic [CW-1:0]       nxt_cnt;

  always_comb begin
    int keep;
    int src;
    int k;
    keep     = int'(cnt) - int'(pop_n);
    nxt_data = ent_data;
    nxt_kill = ent_kill;
    for (int i = 0; i < DEPTH; i++) begin
      src = i + int'(pop_n);
      k   = i - keep;
      if (i < keep) begin
        nxt_data[i*DW +: DW] = ent_data[src*DW +: DW];
        nxt_kill[i]          = ent_kill[src];
      end else if (k < int'(push_n) && k < GW) begin
        nxt_data[i*DW +: DW] = push_data[k*DW +: DW];
        nxt_kill[i]          = push_kill[k];
      end
    end
    nxt_cnt = clr ? '0 : CW'(keep + int'(push_n));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      ent_data <= '0;
      ent_kill <= '0;
    end else begin
      cnt      <= nxt_cnt;
      ent_data <= nxt_data;
      ent_kill <= nxt_kill;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (int'(cnt) - int'(pop_n) + int'(push_n)) <= DEPTH); // R11

  AST_POP_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_n) <= int'(cnt)); // R6

endmodule

// File: rtl/decode_skid_ctrl.sv
`timescale 1ns/1ps
module decode_skid_ctrl #(
  parameter int DW     = 16,
  parameter int GRP_W  = 4,
  parameter int DEC_W  = 2,
  parameter int UP_DLY = 1,
  localparam int GCW   = $clog2(GRP_W + 1),
  localparam int OCW   = $clog2(DEC_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [GCW-1:0]      in_cnt,
  input  logic [GRP_W*DW-1:0] in_data,
  input  logic [GRP_W-1:0]    in_kill,
  input  logic                ds_stall_set,
  input  logic                ds_stall_clr,
  input  logic                flush,
  output logic [OCW-1:0]      out_cnt,
  output logic [DEC_W*DW-1:0] out_data,
  output logic                up_block,
  output logic                up_unblock
);
  import dsb_pkg::*;

  localparam int SKD = skid_depth(UP_DLY, GRP_W);
  localparam int CW  = $clog2(SKD + 1);

  dsb_state_e st_q, st_d;
  logic       stall_q, stall_eff;

  // Internal events, named for the checks.
  logic       ev_blk_req, ev_unb_req, ev_clr;
  dsb_src_e   ev_src;

  // Group picker
  logic [OCW-1:0]      gp_n;
  logic [DEC_W*DW-1:0] gp_data;
  logic [GCW-1:0]      gp_used;

  // Skid picker and storage
  logic [OCW-1:0]      sp_n;
  logic [DEC_W*DW-1:0] sp_data;
  logic [CW-1:0]       sp_used;
  logic [SKD*DW-1:0]   sk_data;
  logic [SKD-1:0]      sk_kill;
  logic [CW-1:0]       sk_cnt;

  logic [CW-1:0]       pop_n;
  logic [GCW-1:0]      push_n;
  logic [GCW-1:0]      push_off;
  logic [GRP_W*DW-1:0] push_data;
  logic [GRP_W-1:0]    push_kill;
  logic [1:0]          pulses;

  assign stall_eff = stall_level(stall_q, ds_stall_set, ds_stall_clr);

  dsb_pick #(.N(GRP_W), .W(DEC_W), .DW(DW)) u_pick_grp (
    .cnt      (in_cnt),
    .data     (in_data),
    .kill     (in_kill),
    .out_n    (gp_n),
    .out_data (gp_data),
    .used_n   (gp_used)
  );

  dsb_pick #(.N(SKD), .W(DEC_W), .DW(DW)) u_pick_skid (
    .cnt      (sk_cnt),
    .data     (sk_data),
    .kill     (sk_kill),
    .out_n    (sp_n),
    .out_data (sp_data),
    .used_n   (sp_used)
  );

  dsb_skid #(.DEPTH(SKD), .GW(GRP_W), .DW(DW)) u_skid (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ev_clr),
    .pop_n     (pop_n),
    .push_n    (push_n),
    .push_data (push_data),
    .push_kill (push_kill),
    .ent_data  (sk_data),
    .ent_kill  (sk_kill),
    .cnt       (sk_cnt)
  );

  // Control: flush, then stall, then drain from group or skid.
  always_comb begin
    dsb_state_e s1;
    int inc;
    int skc;
    inc        = int'(in_cnt);
    skc        = int'(sk_cnt);
    st_d       = st_q;
    s1         = st_q;
    ev_blk_req = 1'b0;
    ev_unb_req = 1'b0;
    ev_clr     = 1'b0;
    ev_src     = SRC_NONE;
    pop_n      = '0;
    push_n     = '0;
    push_off   = '0;
    if (flush) begin
      ev_clr     = 1'b1;
      ev_unb_req = (st_q == ST_BLK) || (st_q == ST_UNB);
      st_d       = ST_SQ;
    end else if (stall_eff) begin
      push_n = in_cnt;
      if (st_q != ST_BLK) begin
        ev_blk_req = 1'b1;
        st_d       = ST_BLK;
      end
    end else begin
      if (st_q == ST_BLK) begin
        if (skc == 0) begin
          ev_unb_req = 1'b1;
          s1         = ST_RUN;
        end else begin
          s1 = ST_UNB;
        end
      end else if (st_q == ST_SQ) begin
        s1 = ST_RUN;
      end
      if (s1 == ST_UNB) begin
        ev_src = SRC_SKID;
        pop_n  = sp_used;
        push_n = in_cnt;
        if (skc - int'(sp_used) + inc == 0) begin
          ev_unb_req = 1'b1;
          st_d       = ST_RUN;
        end else begin
          st_d = ST_UNB;
        end
      end else begin
        ev_src = SRC_GRP;
        st_d   = s1;
        if (inc > int'(gp_used)) begin
          push_off   = gp_used;
          push_n     = GCW'(inc - int'(gp_used));
          ev_blk_req = 1'b1;
          st_d       = ST_BLK;
        end
      end
    end
  end

  // Group entries shifted down past the ones already consumed.
  always_comb begin
    push_data = '0;
    push_kill = '0;
    for (int k = 0; k < GRP_W; k++) begin
      if (k + int'(push_off) < GRP_W) begin
        push_data[k*DW +: DW] = in_data[(k + int'(push_off))*DW +: DW];
        push_kill[k]          = in_kill[k + int'(push_off)];
      end
    end
  end

  assign pulses = settle_pulses(ev_blk_req, ev_unb_req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      stall_q    <= 1'b0;
      out_cnt    <= '0;
      out_data   <= '0;
      up_block   <= 1'b0;
      up_unblock <= 1'b0;
    end else begin
      st_q       <= st_d;
      stall_q    <= stall_eff;
      up_block   <= pulses[1];
      up_unblock <= pulses[0];
      case (ev_src)
        SRC_GRP: begin
          out_cnt  <= gp_n;
          out_data <= gp_data;
        end
        SRC_SKID: begin
          out_cnt  <= sp_n;
          out_data <= sp_data;
        end
        default: begin
          out_cnt  <= '0;
          out_data <= '0;
        end
      endcase
    end
  end

  AST_BLOCK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    up_block |=> !up_block); // R5

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_block && up_unblock)); // R8

  AST_UNBLOCK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    up_unblock |-> (sk_cnt == '0)); // R6

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (out_cnt == '0 && !up_block && sk_cnt == '0)); // R9

  AST_CLR_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ds_stall_clr |-> (stall_q || ds_stall_set)); // R11

  AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_eff && !flush) |=> (out_cnt == '0)); // R5

endmodule

// File: tb/decode_skid_ctrl_bench.sv
`timescale 1ns/1ps
module decode_skid_ctrl_bench;
  localparam int DW = 16, GW = 4, DCW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0]       in_cnt;
  logic [GW*DW-1:0] in_data;
  logic [GW-1:0]    in_kill;
  logic ds_stall_set, ds_stall_clr, flush;
  logic [1:0]        out_cnt;
  logic [DCW*DW-1:0] out_data;
  logic up_block, up_unblock;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  decode_skid_ctrl #(.DW(DW), .GRP_W(GW), .DEC_W(DCW), .UP_DLY(1)) u_decode_skid_ctrl (
    .clk(clk), .rst_n(rst_n), .in_cnt(in_cnt), .in_data(in_data), .in_kill(in_kill),
    .ds_stall_set(ds_stall_set), .ds_stall_clr(ds_stall_clr), .flush(flush),
    .out_cnt(out_cnt), .out_data(out_data), .up_block(up_block), .up_unblock(up_unblock)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    in_cnt = '0; in_data = '0; in_kill = '0;
    ds_stall_set = 1'b0; ds_stall_clr = 1'b0; flush = 1'b0;
  endtask

  task automatic give(input int n, input int base, input logic [GW-1:0] km);
    in_cnt  = 3'(n);
    in_kill = km;
    for (int k = 0; k < GW; k++) in_data[k*DW +: DW] = 16'(base + k);
  endtask

  task automatic step();
    @(posedge clk); #1;
    idle_in();
  endtask

  task automatic chk_out(input int n, input int e0, input int e1, input string tag);
    chk(int'(out_cnt) == n, {tag, " count"}, int'(out_cnt), n);
    if (n > 0) chk(int'(out_data[DW-1:0]) == e0, {tag, " slot0"}, int'(out_data[DW-1:0]), e0);
    if (n > 1) chk(int'(out_data[2*DW-1:DW]) == e1, {tag, " slot1"}, int'(out_data[2*DW-1:DW]), e1);
  endtask

  task automatic chk_pul(input bit b, input bit u, input string tag);
    chk(up_block == b, {tag, " block"}, int'(up_block), int'(b));
    chk(up_unblock == u, {tag, " unblock"}, int'(up_unblock), int'(u));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; idle_in();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk_out(0, 0, 0, "R1 reset");
    chk_pul(0, 0, "R1 reset");
  endtask

  task automatic t_pass();
    do_reset();
    give(2, 'h10, 4'b0000); step();
    chk_out(2, 'h10, 'h11, "R2 two");  chk_pul(0, 0, "R2 two");
    give(1, 'h20, 4'b0000); step();
    chk_out(1, 'h20, 0, "R2 one");
    step();
    chk_out(0, 0, 0, "R2 empty");
  endtask

  task automatic t_kill();
    do_reset();
    give(4, 'h30, 4'b0101); step();
    chk_out(2, 'h31, 'h33, "R3 group kill"); chk_pul(0, 0, "R3 no leftover");
  endtask

  task automatic t_leftover();
    do_reset();
    give(4, 'h40, 4'b0000); step();
    chk_out(2, 'h40, 'h41, "R4 first"); chk_pul(1, 0, "R4 block");
    step();
    chk_out(2, 'h42, 'h43, "R6 drain"); chk_pul(0, 1, "R6 unblock");
    step();
    chk_out(0, 0, 0, "R6 after"); chk_pul(0, 0, "R6 after");
  endtask

  task automatic t_stall();
    do_reset();
    ds_stall_set = 1'b1; give(3, 'h50, 4'b0000); step();
    chk_out(0, 0, 0, "R5 stall"); chk_pul(1, 0, "R5 enter");
    give(2, 'h60, 4'b0000); step();
    chk_out(0, 0, 0, "R5 held"); chk_pul(0, 0, "R5 no repeat");
    ds_stall_clr = 1'b1; give(1, 'h70, 4'b0000); step();
    chk_out(2, 'h50, 'h51, "R6 unb1"); chk_pul(0, 0, "R6 unb1");
    step();
    chk_out(2, 'h52, 'h60, "R6 unb2"); chk_pul(0, 0, "R6 unb2");
    step();
    chk_out(2, 'h61, 'h70, "R6 unb3"); chk_pul(0, 1, "R6 done");
    give(1, 'h80, 4'b0000); step();
    chk_out(1, 'h80, 0, "R6 running"); chk_pul(0, 0, "R6 running");
  endtask

  task automatic t_empty_unblock();
    do_reset();
    ds_stall_set = 1'b1; step();
    chk_pul(1, 0, "R7 block");
    ds_stall_clr = 1'b1; give(2, 'h90, 4'b0000); step();
    chk_out(2, 'h90, 'h91, "R7 pass"); chk_pul(0, 1, "R7 unblock");
  endtask

  task automatic t_cancel();
    do_reset();
    ds_stall_set = 1'b1; step();
    chk_pul(1, 0, "R8 setup");
    ds_stall_clr = 1'b1; give(4, 'hA0, 4'b0000); step();
    chk_out(2, 'hA0, 'hA1, "R8 overlap"); chk_pul(0, 0, "R8 cancel");
    step();
    chk_out(2, 'hA2, 'hA3, "R8 drain"); chk_pul(0, 1, "R8 drain");
  endtask

  task automatic t_flush();
    do_reset();
    ds_stall_set = 1'b1; give(2, 'hB0, 4'b0000); step();
    chk_pul(1, 0, "R9 setup");
    flush = 1'b1; give(2, 'hC0, 4'b0000); step();
    chk_out(0, 0, 0, "R9 flush"); chk_pul(0, 1, "R9 flush over stall");
    ds_stall_clr = 1'b1; give(1, 'hD0, 4'b0000); step();
    chk_out(1, 'hD0, 0, "R10 exit"); chk_pul(0, 0, "R10 exit");
    step();
    chk_out(0, 0, 0, "R9 skid gone");
  endtask

  task automatic t_squash_stall();
    do_reset();
    flush = 1'b1; give(2, 'hE8, 4'b0000); step();
    chk_out(0, 0, 0, "R9 drop"); chk_pul(0, 0, "R9 from idle");
    ds_stall_set = 1'b1; give(1, 'hE0, 4'b0000); step();
    chk_out(0, 0, 0, "R10 stall in squash"); chk_pul(1, 0, "R10 block");
    ds_stall_clr = 1'b1; step();
    chk_out(1, 'hE0, 0, "R10 recover"); chk_pul(0, 1, "R10 recover");
    flush = 1'b1; step();
    flush = 1'b1; step();
    chk_out(0, 0, 0, "R10 squash twice");
    give(2, 'hF0, 4'b0000); step();
    chk_out(2, 'hF0, 'hF1, "R10 clean exit");
  endtask

  task automatic t_capacity();
    do_reset();
    ds_stall_set = 1'b1; give(4, 'h100, 4'b0000); step();
    chk_pul(1, 0, "R11 fill1");
    give(4, 'h104, 4'b0011); step();
    chk_out(0, 0, 0, "R11 full");
    ds_stall_clr = 1'b1; step();
    chk_out(2, 'h100, 'h101, "R11 d1"); chk_pul(0, 0, "R11 d1");
    step();
    chk_out(2, 'h102, 'h103, "R11 d2"); chk_pul(0, 0, "R11 d2");
    step();
    chk_out(2, 'h106, 'h107, "R3 skid kill"); chk_pul(0, 1, "R11 end");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_pass();
    t_kill();
    t_leftover();
    t_stall();
    t_empty_unblock();
    t_cancel();
    t_flush();
    t_squash_stall();
    t_capacity();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule